// File: doc/BRIEF.md
# Read-Strobe Delay Tap Calibration Sweep

This block centres the read-capture delay of a two-lane memory interface. When asked to calibrate, it sets a shared delay tap on both lane outputs and runs one memory self-test per tap, from the lowest tap to the highest. It talks to an external self-test engine through a start output and a status input, and records which taps pass.

When the sweep ends, the block applies the wrapped midpoint of the lowest and highest passing taps to both lanes. If no tap passed, it restores the tap that was in force when calibration began. A wait that never completes is cut short by a timeout, and that tap counts as failing. The pass count and the window edges stay visible on output ports after the sweep.

Top module: `tapcal_sweep`

## Requirements
- R1: After `cal_start`, the taps are swept in ascending order 0, 1, ..., 63. Each tap appears on both `lane0_tap` and `lane1_tap` with identical values, and it is stable for at least one cycle before `bist_start` rises for that tap.
- R2: For each tap, `bist_start` stays high until status bit 0 (done) is seen high. Test done and a pass with count 8 at 3 cycles after start gives a start pulse of exactly 4 cycles. `bist_start` then drops for at least one cycle before the next tap.
- R3: A tap passes only when done is high and status bits 8:1 (the compare count) equal exactly 8. Counts of 7, 9 or 0 fail.
- R4: `pass_count` counts the passing taps. `win_first` is the first passing tap and `win_last` the latest passing tap. Both read 0 while `pass_count` is 0.
- R5: When at least one tap passed, the applied final tap is (win_first + win_last) / 2 modulo 64.
- R6: When no tap passed, the final tap equals the `prev_tap` value captured at the `cal_start` that began the sweep.
- R7: If done does not arrive within TIMEOUT_CYC cycles of `bist_start` high, the tap counts as failing. `bist_start` is then high for exactly TIMEOUT_CYC cycles, and the sweep continues.
- R8: `cal_done` is a one-cycle pulse in the same cycle that the final tap first appears on the lanes. `cal_busy` is high from the cycle after `cal_start` until `cal_done`.
- R9: A `cal_start` raised while a sweep is running has no effect on that sweep or on its result.
- R10: After reset, both lane taps are 0, `bist_start`, `cal_busy` and `cal_done` are low, and `pass_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Begin a calibration sweep (accepted only when idle) |
| prev_tap | input | 6 | Tap in force before calibration, captured at start |
| bist_status | input | 9 | Self-test status: bit 0 done, bits 8:1 compare count |
| lane0_tap | output | 6 | Delay tap for lane 0 |
| lane1_tap | output | 6 | Delay tap for lane 1 |
| bist_start | output | 1 | Self-test start request |
| cal_busy | output | 1 | Sweep in progress |
| cal_done | output | 1 | One-cycle pulse when the final tap is applied |
| pass_count | output | 7 | Number of passing taps in the last sweep |
| win_first | output | 6 | Lowest passing tap (0 if none) |
| win_last | output | 6 | Highest passing tap (0 if none) |

## Verification
The hardest case to reach from the ports is a test engine that never answers. The timeout path is taken only when done stays low for a full window while start is high. The bench's engine model keeps a per-tap hang map, so chosen taps never report done. This mixes timeouts with passes in a single sweep, and each timed-out tap's start pulse length is measured. Near-miss compare counts of 7 and 9, a window that spans the whole range, and a start request injected mid-sweep complete the corner cases.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_GAP    = 2'd3
  } tapcal_state_e;

  localparam int DONE_BIT = 0;
  localparam int CNT_LSB  = 1;
endpackage

// File: rtl/tapcal_judge.sv
module tapcal_judge #(
  parameter int CNT_W      = 8,
  parameter int EXPECT_CNT = 8,
  localparam int ST_W = CNT_W + 1
) (
  input  logic [ST_W-1:0] status,
  output logic            done,
  output logic            pass
);
  import tapcal_pkg::*;
  logic [CNT_W-1:0] cnt_field;

  assign cnt_field = status[CNT_LSB +: CNT_W];
  assign done      = status[DONE_BIT];
  assign pass      = (cnt_field == CNT_W'(EXPECT_CNT));
endmodule

// File: rtl/tapcal_window.sv
module tapcal_window #(
  parameter int TAP_W = 6,
  localparam int CNTW = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rec,
  input  logic             rec_pass,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] first_tap,
  output logic [TAP_W-1:0] last_tap,
  output logic [CNTW-1:0]  count
);
  localparam logic [TAP_W:0] SENTINEL = '1;

  logic [TAP_W:0]   first_q;
  logic [TAP_W-1:0] last_q;
  logic [CNTW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= SENTINEL;
      last_q  <= '0;
      cnt_q   <= '0;
    end else if (clear) begin
      first_q <= SENTINEL;
      last_q  <= '0;
      cnt_q   <= '0;
    end else if (rec && rec_pass) begin
      if (first_q == SENTINEL) first_q <= {1'b0, tap};
      last_q <= tap;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign found     = (first_q != SENTINEL);
  assign first_tap = found ? first_q[TAP_W-1:0] : '0;
  assign last_tap  = last_q;
  assign count     = cnt_q;
endmodule

// File: rtl/tapcal_seq.sv
module tapcal_seq #(
  parameter int TAP_W       = 6,
  parameter int TIMEOUT_CYC = 1000,
  parameter logic [TAP_W-1:0] RST_TAP = '0,
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic [TAP_W-1:0] prev_tap,
  input  logic [TAP_W-1:0] final_tap,
  input  logic             have_pass,
  input  logic             st_done,
  input  logic             st_pass,
  output logic [TAP_W-1:0] lane_tap,
  output logic [TAP_W-1:0] cur_tap,
  output logic [TAP_W-1:0] saved_tap,
  output logic             bist_start,
  output logic             busy,
  output logic             cal_done,
  output logic             sweep_clear,
  output logic             test_end,
  output logic             test_pass,
  output logic             tmo_evt
);
  import tapcal_pkg::*;
  localparam logic [TAP_W-1:0] LAST_TAP = '1;

  tapcal_state_e    state_q;
  logic [TMO_W-1:0] timer_q;
  logic [TAP_W-1:0] tap_q, lane_q, saved_q;
  logic             done_q;
  logic             in_run, tmo_hit;

  assign in_run      = (state_q == ST_RUN);
  assign tmo_hit     = in_run && !st_done && (timer_q == TMO_W'(TIMEOUT_CYC - 1));
  assign test_end    = in_run && (st_done || tmo_hit);
  assign test_pass   = in_run && st_done && st_pass;
  assign tmo_evt     = tmo_hit;
  assign sweep_clear = (state_q == ST_IDLE) && cal_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      tap_q   <= '0;
      lane_q  <= RST_TAP;
      saved_q <= RST_TAP;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cal_start) begin
            saved_q <= prev_tap;
            tap_q   <= '0;
            lane_q  <= '0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          timer_q <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (test_end) state_q <= ST_GAP;
          else          timer_q <= timer_q + 1'b1;
        end
        ST_GAP: begin
          if (tap_q == LAST_TAP) begin
            lane_q  <= have_pass ? final_tap : saved_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tap_q   <= tap_q + 1'b1;
            lane_q  <= tap_q + 1'b1;
            state_q <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_tap   = lane_q;
  assign cur_tap    = tap_q;
  assign saved_tap  = saved_q;
  assign bist_start = in_run;
  assign busy       = (state_q != ST_IDLE);
  assign cal_done   = done_q;
endmodule

// File: rtl/tapcal_sweep.sv
module tapcal_sweep #(
  parameter int TAP_W       = 6,
  parameter int CNT_W       = 8,
  parameter int EXPECT_CNT  = 8,
  parameter int TIMEOUT_CYC = 1000,
  localparam int ST_W = CNT_W + 1,
  localparam int PCW  = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic [TAP_W-1:0] prev_tap,
  input  logic [ST_W-1:0]  bist_status,
  output logic [TAP_W-1:0] lane0_tap,
  output logic [TAP_W-1:0] lane1_tap,
  output logic             bist_start,
  output logic             cal_busy,
  output logic             cal_done,
  output logic [PCW-1:0]   pass_count,
  output logic [TAP_W-1:0] win_first,
  output logic [TAP_W-1:0] win_last
);
  // Wrapped midpoint of the passing window.
  function automatic logic [TAP_W-1:0] mid_tap(input logic [TAP_W-1:0] a,
                                               input logic [TAP_W-1:0] b);
    logic [TAP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TAP_W:1];
  endfunction

  logic             st_done, st_pass, found;
  logic             sweep_clear, test_end, test_pass, tmo_evt;
  logic [TAP_W-1:0] cur_tap, saved_tap, lane_tap, final_tap;

  tapcal_judge #(.CNT_W(CNT_W), .EXPECT_CNT(EXPECT_CNT)) u_judge (
    .status (bist_status),
    .done   (st_done),
    .pass   (st_pass)
  );

  tapcal_window #(.TAP_W(TAP_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sweep_clear),
    .rec       (test_end),
    .rec_pass  (test_pass),
    .tap       (cur_tap),
    .found     (found),
    .first_tap (win_first),
    .last_tap  (win_last),
    .count     (pass_count)
  );

  assign final_tap = mid_tap(win_first, win_last);

  tapcal_seq #(.TAP_W(TAP_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_start   (cal_start),
    .prev_tap    (prev_tap),
    .final_tap   (final_tap),
    .have_pass   (found),
    .st_done     (st_done),
    .st_pass     (st_pass),
    .lane_tap    (lane_tap),
    .cur_tap     (cur_tap),
    .saved_tap   (saved_tap),
    .bist_start  (bist_start),
    .busy        (cal_busy),
    .cal_done    (cal_done),
    .sweep_clear (sweep_clear),
    .test_end    (test_end),
    .test_pass   (test_pass),
    .tmo_evt     (tmo_evt)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      if (g == 0) begin : g_l0
        assign lane0_tap = lane_tap;
      end else begin : g_l1
        assign lane1_tap = lane_tap;
      end
    end
  endgenerate
endmodule

// File: rtl/tapcal_sweep_chk.sv
module tapcal_sweep_chk #(
  parameter int TAP_W      = 6,
  parameter int CNT_W      = 8,
  parameter int EXPECT_CNT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] lane0_tap,
  input logic [TAP_W-1:0] lane1_tap,
  input logic             bist_start,
  input logic [CNT_W:0]   bist_status,
  input logic             cal_done,
  input logic [TAP_W:0]   pass_count,
  input logic             test_end,
  input logic             tmo_evt,
  input logic [TAP_W-1:0] saved_tap
);
  p_lanes_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lane0_tap == lane1_tap);

  p_lane_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_start) |-> $stable(lane0_tap));

  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_start && !test_end) |=> bist_start);

  p_start_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    test_end |=> !bist_start);

  p_near_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_end && bist_status[0] && bist_status[CNT_W:1] != CNT_W'(EXPECT_CNT))
      |=> $stable(pass_count));

  p_count_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pass_count <= (TAP_W+1)'(1 << TAP_W));

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && pass_count == '0) |-> lane0_tap == saved_tap);

  p_tmo_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> !bist_status[0]);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);
endmodule

bind tapcal_sweep tapcal_sweep_chk #(
  .TAP_W(TAP_W), .CNT_W(CNT_W), .EXPECT_CNT(EXPECT_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lane0_tap(lane0_tap), .lane1_tap(lane1_tap),
  .bist_start(bist_start), .bist_status(bist_status), .cal_done(cal_done),
  .pass_count(pass_count), .test_end(test_end), .tmo_evt(tmo_evt),
  .saved_tap(saved_tap)
);

// File: tb/tapcal_sweep_test.sv
module tapcal_sweep_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAP_W = 6;
  localparam int NT    = 1 << TAP_W;
  localparam int TMO   = 12;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic [TAP_W-1:0] prev_tap = '0;
  logic [8:0] bist_status;
  logic [TAP_W-1:0] lane0_tap, lane1_tap, win_first, win_last;
  logic bist_start, cal_busy, cal_done;
  logic [TAP_W:0] pass_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  tapcal_sweep #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .prev_tap(prev_tap),
    .bist_status(bist_status), .lane0_tap(lane0_tap), .lane1_tap(lane1_tap),
    .bist_start(bist_start), .cal_busy(cal_busy), .cal_done(cal_done),
    .pass_count(pass_count), .win_first(win_first), .win_last(win_last)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Test engine model: per-tap compare count and hang map.
  logic [7:0] cnt_map [NT];
  bit         hang_map [NT];
  logic       eng_done = 1'b0;
  int         eng_k = 0;
  assign bist_status = {cnt_map[lane0_tap], eng_done};

  initial forever begin
    @(posedge clk);
    if (!bist_start) begin
      eng_done <= 1'b0;
      eng_k = 0;
    end else begin
      eng_k++;
      if (eng_k == LAT && !hang_map[lane0_tap]) eng_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard of expected start pulses: tap and pulse length.
  int exp_tap_q[$];
  int exp_len_q[$];

  initial begin : monitor
    bit prev_s = 0;
    int len = 0;
    int t0 = 0, t1 = 0;
    forever begin
      @(negedge clk);
      if (bist_start && !prev_s) begin
        t0 = lane0_tap; t1 = lane1_tap; len = 1;
      end else if (bist_start) begin
        len++;
      end else if (prev_s) begin
        if (exp_tap_q.size() == 0) begin
          chk(0, "R1 unexpected start pulse", t0, -1);
        end else begin
          int et, el;
          et = exp_tap_q.pop_front();
          el = exp_len_q.pop_front();
          chk(t0 == et, "R1 sweep order", t0, et);
          chk(t1 == et, "R1 lane1 equal", t1, et);
          chk(len == el, "R2/R7 start length", len, el);
        end
      end
      prev_s = bist_start;
    end
  end

  task automatic clear_maps();
    for (int i = 0; i < NT; i++) begin cnt_map[i] = 8'd0; hang_map[i] = 0; end
  endtask

  task automatic run_cal(input int prev, input int inject, input int e_tap,
                         input int e_cnt, input int e_first, input int e_last,
                         input string tag);
    for (int i = 0; i < NT; i++) begin
      exp_tap_q.push_back(i);
      exp_len_q.push_back(hang_map[i] ? TMO : LAT + 1);
    end
    @(negedge clk);
    prev_tap = TAP_W'(prev);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_busy, {tag, " R8 busy"}, int'(cal_busy), 1);
    if (inject >= 0) begin
      repeat (40) @(negedge clk);
      prev_tap = TAP_W'(inject);
      cal_start = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      cal_start = 1'b0;
    end
    while (!cal_done) @(negedge clk);
    chk(lane0_tap == TAP_W'(e_tap), {tag, " R5/R6 final tap"}, int'(lane0_tap), e_tap);
    chk(lane1_tap == TAP_W'(e_tap), {tag, " R1 final lane1"}, int'(lane1_tap), e_tap);
    chk(int'(pass_count) == e_cnt, {tag, " R4 pass count"}, int'(pass_count), e_cnt);
    chk(int'(win_first) == e_first, {tag, " R4 first"}, int'(win_first), e_first);
    chk(int'(win_last) == e_last, {tag, " R4 last"}, int'(win_last), e_last);
    @(negedge clk);
    chk(!cal_done, {tag, " R8 pulse"}, int'(cal_done), 0);
    chk(!cal_busy, {tag, " R8 idle"}, int'(cal_busy), 0);
    chk(lane0_tap == TAP_W'(e_tap), {tag, " R8 tap held"}, int'(lane0_tap), e_tap);
    chk(exp_tap_q.size() == 0, {tag, " R1 all taps tested"}, exp_tap_q.size(), 0);
    exp_tap_q.delete();
    exp_len_q.delete();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    clear_maps();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(lane0_tap == '0 && lane1_tap == '0, "R10 lanes", int'(lane0_tap), 0);
    chk(!bist_start && !cal_busy && !cal_done, "R10 controls", int'(bist_start), 0);
    chk(pass_count == '0, "R10 count", int'(pass_count), 0);

    // Contiguous window 10..20 -> 15
    clear_maps();
    for (int i = 10; i <= 20; i++) cnt_map[i] = 8'd8;
    run_cal(5, -1, 15, 11, 10, 20, "win");

    // No pass; restore previous tap, mid-sweep start ignored (R6, R9)
    clear_maps();
    run_cal(37, 5, 37, 0, 0, 0, "none");

    // Scattered passes 5, 40, 62 -> (5+62)/2 = 33
    clear_maps();
    cnt_map[5] = 8'd8; cnt_map[40] = 8'd8; cnt_map[62] = 8'd8;
    run_cal(0, -1, 33, 3, 5, 62, "scatter");

    // R3 near misses; only 63 passes
    clear_maps();
    for (int i = 0; i < 63; i++) cnt_map[i] = (i % 2 == 0) ? 8'd7 : 8'd9;
    cnt_map[63] = 8'd8;
    run_cal(12, -1, 63, 1, 63, 63, "nearmiss");

    // R7 timeouts: pass 0..3 with tap 2 hung -> first 0 last 3 -> 1
    clear_maps();
    for (int i = 0; i <= 3; i++) cnt_map[i] = 8'd8;
    hang_map[2] = 1; hang_map[30] = 1;
    run_cal(9, -1, 1, 3, 0, 3, "timeout");

    // Full range passes -> (0+63)/2 = 31
    clear_maps();
    for (int i = 0; i < NT; i++) cnt_map[i] = 8'd8;
    run_cal(50, -1, 31, 64, 0, 63, "full");

    report();
  end
endmodule